// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Automatic Repeat

This block sends bytes over a single shared, open-drain I/O line in the asynchronous character format used by contact smart cards. A byte goes out as a low start bit, then eight data bits starting with the least significant, then an even parity bit. After the parity bit the transmitter lets go of the line for two bit times of guard. A receiver that found a parity error pulls the line low during the first of those guard bits to ask for the byte again.

When that error signal is seen and repeats are allowed, the block adds one more bit time of guard and sends the same byte again without taking a new one from its input. A 3-bit repeat limit sets how many extra sends a byte may get. Zero turns repeats off. When a byte is refused on its final allowed send, a sticky flag records that the repeats ran out, and the block goes on to the next byte. Bit timing comes from an external baud tick, and each bit lasts a fixed number of ticks.

Top module: `sc_t0_tx`

## Requirements
- R1: After a byte is accepted, the line carries a low start bit, then in_data bit 0 through bit 7 in that order, each bit lasting TICKS_PER_BIT baud ticks. The start bit begins in the cycle after the accepting edge.
- R2: The bit after bit 7 is a parity bit equal to the XOR of the eight data bits, so the nine bits together hold an even number of ones.
- R3: line_drive_low is 1 only for a 0 start, data or parity bit. It stays 0 for 1 bits, for every guard bit and while idle.
- R4: The line is examined only once per send, on the baud tick at position TICKS_PER_BIT/2 of the first guard bit. A low line there is a NACK and produces exactly one nack_seen pulse. A low line in the second guard bit alone is ignored.
- R5: With no NACK, the send ends two guard bit times after the parity bit, and in_ready returns to 1 in the cycle that follows.
- R6: After a NACK with repeats remaining, the same byte is sent again. Its start bit begins exactly three bit times after the parity bit ends.
- R7: With max_iter equal to 0, a NACKed byte is never sent again.
- R8: A byte is sent at most max_iter+1 times. A NACK on the last allowed send sets iter_exhausted, and in_ready returns three bit times after the parity bit.
- R9: iter_exhausted stays 1 until reset, across later bytes.
- R10: The repeat count starts from zero for every accepted byte, so each byte gets its full allowance of repeats.
- R11: While rst is held and just after it, in_ready is 1, line_drive_low is 0 and iter_exhausted is 0.
- R12: in_ready is 0 for the whole send, and in_valid and in_data have no effect on the byte being sent or on what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Timing tick; TICKS_PER_BIT ticks make one bit time |
| max_iter | input | ITER_W | Repeat limit; 0 turns repeats off |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block is idle and takes a byte on in_valid |
| line_in | input | 1 | Level of the shared I/O line |
| line_drive_low | output | 1 | Open-drain enable; 1 pulls the line low |
| nack_seen | output | 1 | One-cycle pulse per NACK detected |
| iter_exhausted | output | 1 | Sticky: a byte ran out of repeats |

## Verification
The bench builds the block with TICKS_PER_BIT set to 4, ITER_W set to 3 and baud_tick held high. Every bit therefore lasts exactly four clocks, and one send with its guard time fits in 48 or 52 cycles. This lets the bench, acting as the card, check each bit, the position of the guard-time sample and the start of a repeat down to the exact cycle. With a 3-bit limit, the full range of repeat settings can be run within the cycle budget, including 0 and the maximum of seven repeats, which gives eight sends of one byte.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD1,
        ST_GUARD2,
        ST_GUARDX
    } tx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 parity;
    } tx_char_t;

    function automatic logic even_parity(input logic [DATA_BITS-1:0] d);
        return ^d;
    endfunction

endpackage

// File: rtl/sc_t0_bit_timer.sv
module sc_t0_bit_timer #(
    parameter int TICKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic baud_tick,
    output logic bit_end,
    output logic mid_tick
);
    localparam int SW   = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int HALF = TICKS_PER_BIT / 2;

    logic [SW-1:0] sub;

    assign bit_end  = run && baud_tick && (sub == SW'(TICKS_PER_BIT - 1));
    assign mid_tick = run && baud_tick && (sub == SW'(HALF));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub <= '0;
        end else if (bit_end) begin
            sub <= '0;
        end else if (baud_tick) begin
            sub <= sub + 1'b1;
        end
    end

    // R4: the sample point and the bit end never share one tick
    p_mid_not_end_r4: assert property (@(posedge clk) disable iff (rst)
        mid_tick |-> !bit_end);

endmodule

// File: rtl/sc_t0_retry_ctl.sv
module sc_t0_retry_ctl #(
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              decide,
    input  logic [ITER_W-1:0] max_iter,
    output logic              resend,
    output logic              exhausted
);
    logic [ITER_W-1:0] rep_cnt;

    assign resend = (max_iter != '0) && (rep_cnt < max_iter);

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_cnt   <= '0;
            exhausted <= 1'b0;
        end else begin
            if (accept) begin
                rep_cnt <= '0;
            end else if (decide && resend) begin
                rep_cnt <= rep_cnt + 1'b1;
            end
            if (decide && !resend) begin
                exhausted <= 1'b1;
            end
        end
    end

    p_zero_no_resend_r7: assert property (@(posedge clk) disable iff (rst)
        (max_iter == '0) |-> !resend);

    p_count_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (rep_cnt == '0));

    p_exhaust_set_r8: assert property (@(posedge clk) disable iff (rst)
        (decide && !resend) |=> exhausted);

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        exhausted |=> exhausted);

endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
    import sc_t0_pkg::*;
#(
    parameter int TICKS_PER_BIT = 4,
    parameter int ITER_W        = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [ITER_W-1:0] max_iter,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              line_in,
    output logic              line_drive_low,
    output logic              nack_seen,
    output logic              iter_exhausted
);
    localparam int IDX_W = $clog2(DATA_BITS);

    tx_state_e        state;
    tx_char_t         chr;
    logic [IDX_W-1:0] idx;
    logic             nack_lat;
    logic             bit_end;
    logic             mid_tick;
    logic             accept;
    logic             decide;
    logic             resend;
    logic             nack_now;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign decide   = bit_end && (state == ST_GUARDX);
    assign nack_now = (state == ST_GUARD1) && mid_tick && !line_in;

    sc_t0_bit_timer #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (state != ST_IDLE),
        .baud_tick(baud_tick),
        .bit_end  (bit_end),
        .mid_tick (mid_tick)
    );

    sc_t0_retry_ctl #(
        .ITER_W(ITER_W)
    ) u_retry (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .decide   (decide),
        .max_iter (max_iter),
        .resend   (resend),
        .exhausted(iter_exhausted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            chr       <= '0;
            idx       <= '0;
            nack_lat  <= 1'b0;
            nack_seen <= 1'b0;
        end else begin
            nack_seen <= nack_now;
            if (state == ST_START) begin
                nack_lat <= 1'b0;
            end else if (nack_now) begin
                nack_lat <= 1'b1;
            end
            if (accept) begin
                chr.data   <= in_data;
                chr.parity <= even_parity(in_data);
                state      <= ST_START;
            end else if (bit_end) begin
                case (state)
                    ST_START: begin
                        idx   <= '0;
                        state <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (idx == IDX_W'(DATA_BITS - 1)) begin
                            state <= ST_PARITY;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    ST_PARITY: state <= ST_GUARD1;
                    ST_GUARD1: state <= ST_GUARD2;
                    ST_GUARD2: state <= nack_lat ? ST_GUARDX : ST_IDLE;
                    ST_GUARDX: state <= resend ? ST_START : ST_IDLE;
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            ST_START:  line_drive_low = 1'b1;
            ST_DATA:   line_drive_low = ~chr.data[idx];
            ST_PARITY: line_drive_low = ~chr.parity;
            default:   line_drive_low = 1'b0;
        endcase
    end

    p_accept_start_r1: assert property (@(posedge clk) disable iff (rst)
        accept |=> (line_drive_low && !in_ready));

    p_resend_start_r6: assert property (@(posedge clk) disable iff (rst)
        (decide && resend) |=> (line_drive_low && !in_ready));

    p_drop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (decide && !resend) |=> (in_ready && iter_exhausted));

    p_nack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        nack_seen |=> !nack_seen);

    p_busy_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !$past(in_ready) && !$past(bit_end)) |-> $stable(line_drive_low));

endmodule

// File: tb/sc_t0_tx_tb.sv
module sc_t0_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b1;
    logic [2:0] max_iter = 3'd0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       line_drive_low;
    logic       nack_seen;
    logic       iter_exhausted;
    logic       card_pull = 1'b0;
    logic       line;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nack_cnt = 0;

    assign line = ~(line_drive_low | card_pull);

    always #5 clk = ~clk;

    sc_t0_tx #(
        .TICKS_PER_BIT(4),
        .ITER_W(3)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .baud_tick     (baud_tick),
        .max_iter      (max_iter),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .line_in       (line),
        .line_drive_low(line_drive_low),
        .nack_seen     (nack_seen),
        .iter_exhausted(iter_exhausted)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (nack_seen) nack_cnt <= nack_cnt + 1;
    end

    initial begin
        wait (cyc > 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1 && line_drive_low == 1'b0 && iter_exhausted == 1'b0,
            "R11 reset outputs", {in_ready, line_drive_low, iter_exhausted}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && line_drive_low == 1'b0 && iter_exhausted == 1'b0,
            "R11 after reset", {in_ready, line_drive_low, iter_exhausted}, 3'b100);
    endtask

    task automatic push(input logic [7:0] d);
        while (in_ready !== 1'b1) @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // mode 0: no pull, 1: NACK in first guard bit, 2: pull in second guard bit only
    // Returns at the negedge of cycle 47 of the send (cycle 0 = first start-bit cycle)
    task automatic rx_frame(input int mode, output logic [7:0] d, output logic p);
        int w = 0;
        bit g_ok = 1'b1;
        while (line_drive_low !== 1'b1 && w < 4000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 4000, "R1 start bit appears", w, 0);
        repeat (2) @(negedge clk);
        chk(line == 1'b0, "R1 start bit low", line, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (4) @(negedge clk);
            d[i] = line;
        end
        repeat (4) @(negedge clk);
        p = line;
        repeat (2) @(negedge clk);
        card_pull = (mode == 1);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            if (line_drive_low) g_ok = 1'b0;
        end
        @(negedge clk);
        card_pull = (mode == 2);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            if (line_drive_low) g_ok = 1'b0;
        end
        card_pull = 1'b0;
        chk(g_ok, "R3 line released in guard", g_ok, 1);
    endtask

    task automatic run_char(input logic [7:0] d, input int nacks, input int m);
        int sends = 0;
        int base;
        int exp_sends;
        int exp_nacks;
        bit done = 1'b0;
        logic [7:0] rd;
        logic rp;
        exp_sends = (nacks > m) ? m + 1 : nacks + 1;
        exp_nacks = (nacks > m) ? m + 1 : nacks;
        max_iter  = 3'(m);
        base      = nack_cnt;
        push(d);
        for (int s = 0; s < 9 && !done; s++) begin
            rx_frame((s < nacks) ? 1 : 0, rd, rp);
            sends++;
            chk(rd == d, "R1 data bits LSB first", rd, d);
            chk(rp == ^d, "R2 even parity", rp, ^d);
            if (s >= nacks) begin
                chk(in_ready == 1'b0, "R5 busy through guard", in_ready, 0);
                @(negedge clk);
                chk(in_ready == 1'b1, "R5 ready after two guard bits", in_ready, 1);
                done = 1'b1;
            end else if (s < m) begin
                repeat (4) @(negedge clk);
                chk(line_drive_low == 1'b0, "R6 no early repeat", line_drive_low, 0);
                @(negedge clk);
                chk(line_drive_low == 1'b1, "R6 repeat start at 3 bit times", line_drive_low, 1);
            end else begin
                repeat (4) @(negedge clk);
                chk(in_ready == 1'b0, "R8 busy through long guard", in_ready, 0);
                @(negedge clk);
                chk(in_ready == 1'b1 && iter_exhausted == 1'b1, "R8 drop and flag",
                    {in_ready, iter_exhausted}, 2'b11);
                done = 1'b1;
            end
        end
        chk(sends == exp_sends, (m == 0) ? "R7 send count, repeats off" : "R8 send count",
            sends, exp_sends);
        chk(nack_cnt - base == exp_nacks, "R4 nack pulses", nack_cnt - base, exp_nacks);
    endtask

    task automatic t_plain();
        run_char(8'hA5, 0, 2);
        run_char(8'h01, 0, 2);
        run_char(8'hFE, 0, 2);
        chk(iter_exhausted == 1'b0, "R8 no flag without NACK", iter_exhausted, 0);
    endtask

    task automatic t_guard2_pull();
        logic [7:0] rd;
        logic rp;
        int base = nack_cnt;
        max_iter = 3'd3;
        push(8'h3C);
        rx_frame(2, rd, rp);
        chk(rd == 8'h3C, "R1 data", rd, 8'h3C);
        @(negedge clk);
        chk(in_ready == 1'b1, "R4 second guard pull ignored", in_ready, 1);
        chk(nack_cnt == base, "R4 no nack pulse", nack_cnt - base, 0);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] rd;
        logic rp;
        bit quiet = 1'b1;
        max_iter = 3'd1;
        push(8'h96);
        fork
            rx_frame(0, rd, rp);
            begin
                @(negedge clk);
                in_data  = 8'h0F;
                in_valid = 1'b1;
                chk(in_ready == 1'b0, "R12 not ready while sending", in_ready, 0);
                repeat (20) @(negedge clk);
                in_valid = 1'b0;
            end
        join
        chk(rd == 8'h96, "R12 byte unchanged", rd, 8'h96);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (line_drive_low) quiet = 1'b0;
        end
        chk(quiet, "R12 no extra send", quiet, 1);
    endtask

    task automatic t_retry_ok();
        run_char(8'h5A, 1, 2);
        chk(iter_exhausted == 1'b0, "R6 recovered, no flag", iter_exhausted, 0);
    endtask

    task automatic t_count_reset();
        run_char(8'hC3, 2, 2);
        run_char(8'h3A, 2, 2);
        chk(iter_exhausted == 1'b0, "R10 fresh allowance per byte", iter_exhausted, 0);
    endtask

    task automatic t_zero();
        run_char(8'h77, 1, 0);
        run_char(8'h12, 0, 0);
        chk(iter_exhausted == 1'b1, "R9 flag stays set", iter_exhausted, 1);
    endtask

    task automatic t_max();
        run_char(8'hE1, 9, 7);
    endtask

    initial begin
        do_reset();
        t_plain();
        t_guard2_pull();
        t_busy_ignore();
        t_retry_ok();
        t_count_reset();
        t_zero();
        do_reset();
        t_max();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule